// File: doc/BRIEF.md
# Programmable-Timing Parallel Bus Master

This block turns single read and write requests from an internal request/acknowledge port into cycles on an external parallel bus of the kind used for NOR flash, FPGAs and peripheral chips. It drives one chip select, an address-valid strobe, write and output enables and a full address bus. It also drives a data bus that can optionally carry the low address bits before data (multiplexed mode). A ready input from the device stretches each access.

Every phase length comes from its own configuration field, and a field value of n gives n+1 clock cycles. Each strobe has its own polarity bit. Data width (16 or 32 lines) and multiplexing are also chosen by configuration. The block does no chip-select decoding. It serves one device window of up to 256 MB (28 address bits by default). Configuration inputs must stay stable while a request is in progress. Suggested start-up values are: setup 4, address-valid 1, multiplexed-address 1, write 1, read 1, ready-wait 3, hold 1.

The data bus is presented as separate output, per-line output-enable and input vectors, for a pad ring to combine.

Top module: `pbus_master`

## Requirements
- R1: Each accepted request runs the phases idle, setup, address, strobe, ready wait, hold, then back to idle. A request is accepted only in idle while `req_valid_i` is high. `req_ack_o` is high for exactly one cycle, the last hold cycle.
- R2: For the first `cfg_ce_setup_i`+1 cycles after acceptance, chip select stays inactive while `bus_addr_o` already carries the request address. Chip select then becomes active.
- R3: Address valid is active for `cfg_adv_w_i`+1 cycles, starting in the first cycle of chip select. No strobe is active during that time.
- R4: The address phase lasts `cfg_adv_w_i`+1 cycles. In multiplexed mode (`cfg_mux_i`=1) it lasts max(`cfg_adv_w_i`,`cfg_mux_w_i`)+1 cycles, and during its first `cfg_mux_w_i`+1 cycles the data lines carry address bits [DW-1:0]. With multiplexing off, the data lines are not driven in the address phase.
- R5: Write enable (on writes) or output enable (on reads) is active for the strobe field plus one (`cfg_we_w_i` or `cfg_oe_w_i`), then through the whole ready wait. It is never the opposite strobe.
- R6: After the strobe field expires, the ready input is ignored for `cfg_wait_w_i`+1 cycles. After that, the block checks ready every cycle and waits for as long as it takes.
- R7: With `cfg_rdy_early_i`=0, read data is captured in the cycle ready is first seen active. With it set to 1, data is captured in the following cycle, and the strobe stays active one extra cycle.
- R8: After the strobe deasserts, chip select stays active for `cfg_hold_w_i`+1 cycles. The last of these is the acknowledge cycle.
- R9: On a write, the data lines drive the write data from the first strobe cycle through the last hold cycle. On a read, they are released (output enable 0) for the rest of the access once the address phase ends.
- R10: With `cfg_wide_i`=0, only data lines [15:0] are ever driven, and read data bits [31:16] return as 0. With it set to 1, all 32 lines are used.
- R11: Chip select, address valid, both strobes and ready are each active low when their invert bit is 0 and active high when it is 1. In idle, every output strobe sits at its inactive level.
- R12: If ready has not been seen after TO_CYC cycles of checking, the access moves to hold and completes with `rsp_err_o` high in the acknowledge cycle. Otherwise `rsp_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request pending; held until acknowledge |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| req_ack_o | output | 1 | Request complete (one cycle) |
| rsp_rdata_o | output | DW | Read data, valid with acknowledge |
| rsp_err_o | output | 1 | Ready timeout, valid with acknowledge |
| cfg_wide_i | input | 1 | 1 = 32-bit data, 0 = 16-bit |
| cfg_mux_i | input | 1 | Address shares the data lines |
| cfg_rdy_early_i | input | 1 | Ready leads data by one cycle |
| cfg_rdy_inv_i | input | 1 | Ready active high |
| cfg_adv_inv_i | input | 1 | Address valid active high |
| cfg_stb_inv_i | input | 1 | Write/output enables active high |
| cfg_cs_inv_i | input | 1 | Chip select active high |
| cfg_ce_setup_i | input | 4 | Setup cycles before chip select, minus one |
| cfg_adv_w_i | input | 4 | Address-valid width, minus one |
| cfg_mux_w_i | input | 4 | Multiplexed address width, minus one |
| cfg_we_w_i | input | 4 | Write strobe width, minus one |
| cfg_hold_w_i | input | 4 | Hold width, minus one |
| cfg_oe_w_i | input | 8 | Read strobe width, minus one |
| cfg_wait_w_i | input | 8 | Ready-ignore cycles, minus one |
| bus_cs_o | output | 1 | Chip select |
| bus_adv_o | output | 1 | Address valid |
| bus_we_o | output | 1 | Write enable |
| bus_oe_o | output | 1 | Output enable |
| bus_addr_o | output | AW | Address lines |
| bus_ad_o | output | DW | Data/address lines, outgoing value |
| bus_ad_oe_o | output | DW | Per-line drive enable |
| bus_ad_i | input | DW | Data lines, incoming value |
| bus_rdy_i | input | 1 | Device ready |

## Verification
Several rules are checked on every cycle:
- the acknowledge is a single-cycle pulse;
- chip select survives the fall of a strobe;
- address valid never overlaps a strobe;
- the data lines are released while output enable is active;
- the upper lanes stay undriven in narrow mode;
- a ready seen while the block is checking never leads to a timeout.

Exact phase lengths, capture timing under both ready options, late ready, the timeout path and polarity levels can only be shown by the bench's directed accesses. Those accesses count cycles at the pins against the programmed fields.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_ADDR  = 3'd2,
    PH_STRB  = 3'd3,
    PH_WAIT  = 3'd4,
    PH_DATA  = 3'd5,
    PH_HOLD  = 3'd6
  } phase_e;

  typedef struct packed {
    logic [3:0] ce_setup;
    logic [3:0] adv_w;
    logic [3:0] mux_w;
    logic [3:0] we_w;
    logic [3:0] hold_w;
    logic [7:0] oe_w;
    logic [7:0] wait_w;
    logic       mux_en;
    logic       rdy_early;
  } timing_t;

endpackage

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int AW     = 28,
  parameter int DW     = 32,
  parameter int TO_CYC = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  timing_t       tm_i,
  input  logic          rdy_act_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          cs_act_o,
  output logic          adv_act_o,
  output logic          we_act_o,
  output logic          oe_act_o,
  output logic          ad_addr_o,
  output logic          ad_wdata_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          ack_o,
  output logic          err_o
);

  localparam int TOW = $clog2(TO_CYC + 1);

  phase_e        ph_q, nxt_ph;
  logic [7:0]    cnt_q, lim;
  logic          last, armed_q, write_q, err_q, to_done, strobe_ph;
  logic [TOW-1:0] to_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [3:0]    addr_lim;

  // address phase covers the longer of adv and muxed address
  assign addr_lim = (tm_i.mux_en && (tm_i.mux_w > tm_i.adv_w)) ? tm_i.mux_w : tm_i.adv_w;

  always_comb begin
    case (ph_q)
      PH_SETUP: lim = {4'd0, tm_i.ce_setup};
      PH_ADDR:  lim = {4'd0, addr_lim};
      PH_STRB:  lim = write_q ? {4'd0, tm_i.we_w} : tm_i.oe_w;
      PH_WAIT:  lim = tm_i.wait_w;
      PH_HOLD:  lim = {4'd0, tm_i.hold_w};
      default:  lim = 8'd0;
    endcase
  end

  always_comb begin
    case (ph_q)
      PH_SETUP: nxt_ph = PH_ADDR;
      PH_ADDR:  nxt_ph = PH_STRB;
      PH_STRB:  nxt_ph = PH_WAIT;
      default:  nxt_ph = PH_IDLE;
    endcase
  end

  assign last    = (cnt_q == lim);
  assign to_done = (to_q == TOW'(TO_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      write_q <= 1'b0;
      err_q   <= 1'b0;
      to_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (req_valid_i) begin
            ph_q    <= PH_SETUP;
            cnt_q   <= '0;
            write_q <= req_write_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            err_q   <= 1'b0;
            armed_q <= 1'b0;
            to_q    <= '0;
          end
        end
        PH_WAIT: begin
          if (!armed_q) begin
            if (last) armed_q <= 1'b1;
            else cnt_q <= cnt_q + 8'd1;
          end else if (rdy_act_i) begin
            if (tm_i.rdy_early) begin
              ph_q <= PH_DATA;
            end else begin
              if (!write_q) rdata_q <= rd_data_i;
              ph_q  <= PH_HOLD;
              cnt_q <= '0;
            end
          end else if (to_done) begin
            err_q <= 1'b1;
            ph_q  <= PH_HOLD;
            cnt_q <= '0;
          end else begin
            to_q <= to_q + TOW'(1);
          end
        end
        PH_DATA: begin
          if (!write_q) rdata_q <= rd_data_i;
          ph_q  <= PH_HOLD;
          cnt_q <= '0;
        end
        default: begin
          if (last) begin
            ph_q  <= nxt_ph;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 8'd1;
          end
        end
      endcase
    end
  end

  assign strobe_ph  = (ph_q == PH_STRB) || (ph_q == PH_WAIT) || (ph_q == PH_DATA);
  assign cs_act_o   = (ph_q != PH_IDLE) && (ph_q != PH_SETUP);
  assign adv_act_o  = (ph_q == PH_ADDR) && (cnt_q <= {4'd0, tm_i.adv_w});
  assign we_act_o   = strobe_ph && write_q;
  assign oe_act_o   = strobe_ph && !write_q;
  assign ad_addr_o  = (ph_q == PH_ADDR) && tm_i.mux_en && (cnt_q <= {4'd0, tm_i.mux_w});
  assign ad_wdata_o = write_q && (strobe_ph || (ph_q == PH_HOLD));
  assign addr_o     = (ph_q != PH_IDLE) ? addr_q : '0;
  assign wdata_o    = wdata_q;
  assign rdata_o    = rdata_q;
  assign ack_o      = (ph_q == PH_HOLD) && last;
  assign err_o      = ack_o && err_q;

  assert_ack_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  assert_adv_no_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_act_o |-> (cs_act_o && !we_act_o && !oe_act_o));

  assert_cs_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_act_o || oe_act_o) |-> cs_act_o);

  assert_ready_no_err_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_WAIT && armed_q && rdy_act_i) |=> !err_q);

endmodule

// File: rtl/pbus_pins.sv
module pbus_pins #(
  parameter int AW = 28,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_act_i,
  input  logic          adv_act_i,
  input  logic          we_act_i,
  input  logic          oe_act_i,
  input  logic          ad_addr_i,
  input  logic          ad_wdata_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wide_i,
  input  logic          cs_inv_i,
  input  logic          adv_inv_i,
  input  logic          stb_inv_i,
  input  logic          rdy_inv_i,
  input  logic [DW-1:0] bus_ad_i,
  input  logic          bus_rdy_i,
  output logic          bus_cs_o,
  output logic          bus_adv_o,
  output logic          bus_we_o,
  output logic          bus_oe_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_ad_o,
  output logic [DW-1:0] bus_ad_oe_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rdy_act_o
);

  localparam int NW = DW / 2;
  localparam int NL = DW / NW;

  logic [DW-1:0] aval, dval;
  logic          drive;

  // invert bit set = active high
  assign bus_cs_o   = cs_inv_i  ? cs_act_i  : !cs_act_i;
  assign bus_adv_o  = adv_inv_i ? adv_act_i : !adv_act_i;
  assign bus_we_o   = stb_inv_i ? we_act_i  : !we_act_i;
  assign bus_oe_o   = stb_inv_i ? oe_act_i  : !oe_act_i;
  assign rdy_act_o  = rdy_inv_i ? bus_rdy_i : !bus_rdy_i;
  assign bus_addr_o = addr_i;

  assign aval  = DW'(addr_i);
  assign dval  = ad_addr_i ? aval : wdata_i;
  assign drive = ad_addr_i || ad_wdata_i;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam bit BASE_LANE = (g == 0);
    logic lane_on;
    assign lane_on = BASE_LANE || wide_i;
    assign bus_ad_oe_o[g*NW +: NW] = {NW{drive && lane_on}};
    assign bus_ad_o[g*NW +: NW]    = (drive && lane_on) ? dval[g*NW +: NW] : '0;
    assign rd_data_o[g*NW +: NW]   = lane_on ? bus_ad_i[g*NW +: NW] : '0;
  end

  assert_read_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_act_i |-> (bus_ad_oe_o == '0));

  assert_narrow_lanes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |-> (bus_ad_oe_o[DW-1:NW] == '0));

endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int AW     = 28,
  parameter int DW     = 32,
  parameter int TO_CYC = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ack_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_err_o,
  input  logic          cfg_wide_i,
  input  logic          cfg_mux_i,
  input  logic          cfg_rdy_early_i,
  input  logic          cfg_rdy_inv_i,
  input  logic          cfg_adv_inv_i,
  input  logic          cfg_stb_inv_i,
  input  logic          cfg_cs_inv_i,
  input  logic [3:0]    cfg_ce_setup_i,
  input  logic [3:0]    cfg_adv_w_i,
  input  logic [3:0]    cfg_mux_w_i,
  input  logic [3:0]    cfg_we_w_i,
  input  logic [3:0]    cfg_hold_w_i,
  input  logic [7:0]    cfg_oe_w_i,
  input  logic [7:0]    cfg_wait_w_i,
  output logic          bus_cs_o,
  output logic          bus_adv_o,
  output logic          bus_we_o,
  output logic          bus_oe_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_ad_o,
  output logic [DW-1:0] bus_ad_oe_o,
  input  logic [DW-1:0] bus_ad_i,
  input  logic          bus_rdy_i
);

  timing_t       tm;
  logic          cs_act, adv_act, we_act, oe_act, ad_addr, ad_wdata, rdy_act;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rd_data;

  assign tm = '{ce_setup: cfg_ce_setup_i, adv_w: cfg_adv_w_i, mux_w: cfg_mux_w_i,
                we_w: cfg_we_w_i, hold_w: cfg_hold_w_i, oe_w: cfg_oe_w_i,
                wait_w: cfg_wait_w_i, mux_en: cfg_mux_i, rdy_early: cfg_rdy_early_i};

  pbus_seq #(.AW(AW), .DW(DW), .TO_CYC(TO_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .tm_i        (tm),
    .rdy_act_i   (rdy_act),
    .rd_data_i   (rd_data),
    .cs_act_o    (cs_act),
    .adv_act_o   (adv_act),
    .we_act_o    (we_act),
    .oe_act_o    (oe_act),
    .ad_addr_o   (ad_addr),
    .ad_wdata_o  (ad_wdata),
    .addr_o      (addr),
    .wdata_o     (wdata),
    .rdata_o     (rsp_rdata_o),
    .ack_o       (req_ack_o),
    .err_o       (rsp_err_o)
  );

  pbus_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_act_i    (cs_act),
    .adv_act_i   (adv_act),
    .we_act_i    (we_act),
    .oe_act_i    (oe_act),
    .ad_addr_i   (ad_addr),
    .ad_wdata_i  (ad_wdata),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .wide_i      (cfg_wide_i),
    .cs_inv_i    (cfg_cs_inv_i),
    .adv_inv_i   (cfg_adv_inv_i),
    .stb_inv_i   (cfg_stb_inv_i),
    .rdy_inv_i   (cfg_rdy_inv_i),
    .bus_ad_i    (bus_ad_i),
    .bus_rdy_i   (bus_rdy_i),
    .bus_cs_o    (bus_cs_o),
    .bus_adv_o   (bus_adv_o),
    .bus_we_o    (bus_we_o),
    .bus_oe_o    (bus_oe_o),
    .bus_addr_o  (bus_addr_o),
    .bus_ad_o    (bus_ad_o),
    .bus_ad_oe_o (bus_ad_oe_o),
    .rd_data_o   (rd_data),
    .rdy_act_o   (rdy_act)
  );

endmodule

// File: tb/tb_pbus_master.sv
module tb_pbus_master;

  localparam int AW = 28;
  localparam int DW = 32;
  localparam int TO = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ack, err;
  logic [DW-1:0] rdata;
  logic c_wide, c_mux, c_early, c_rinv, c_ainv, c_sinv, c_cinv;
  logic [3:0] c_ce, c_adv, c_muxw, c_we, c_hold;
  logic [7:0] c_oe, c_wait;
  logic cs, adv, we, oe;
  logic [AW-1:0] baddr;
  logic [DW-1:0] ad_o, ad_oe;
  logic [DW-1:0] ad_i = '0;
  logic          rdy = 1'b1;

  int  checks = 0, fails = 0;
  int  rdy_from = 0;
  bit  rdy_never = 0;
  bit  done = 0;

  pbus_master #(.AW(AW), .DW(DW), .TO_CYC(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ack_o(ack), .rsp_rdata_o(rdata), .rsp_err_o(err),
    .cfg_wide_i(c_wide), .cfg_mux_i(c_mux), .cfg_rdy_early_i(c_early),
    .cfg_rdy_inv_i(c_rinv), .cfg_adv_inv_i(c_ainv), .cfg_stb_inv_i(c_sinv),
    .cfg_cs_inv_i(c_cinv), .cfg_ce_setup_i(c_ce), .cfg_adv_w_i(c_adv),
    .cfg_mux_w_i(c_muxw), .cfg_we_w_i(c_we), .cfg_hold_w_i(c_hold),
    .cfg_oe_w_i(c_oe), .cfg_wait_w_i(c_wait),
    .bus_cs_o(cs), .bus_adv_o(adv), .bus_we_o(we), .bus_oe_o(oe),
    .bus_addr_o(baddr), .bus_ad_o(ad_o), .bus_ad_oe_o(ad_oe),
    .bus_ad_i(ad_i), .bus_rdy_i(rdy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_default();
    c_wide = 1; c_mux = 0; c_early = 0;
    c_rinv = 0; c_ainv = 0; c_sinv = 0; c_cinv = 0;
    c_ce = 4; c_adv = 1; c_muxw = 1; c_we = 1; c_hold = 1; c_oe = 1; c_wait = 3;
    rdy_from = 0; rdy_never = 0;
  endtask

  function automatic bit act_of(input logic pin, input logic inv);
    return inv ? pin : !pin;
  endfunction

  // R11 idle levels
  task automatic chk_idle(input string tag);
    chk(act_of(cs, c_cinv) == 0 && act_of(adv, c_ainv) == 0 &&
        act_of(we, c_sinv) == 0 && act_of(oe, c_sinv) == 0,
        {"R11 idle strobes ", tag}, {cs, adv, we, oe}, {!c_cinv, !c_ainv, !c_sinv, !c_sinv});
    chk(ad_oe == '0 && ack == 0, {"R1 idle bus ", tag}, ad_oe, 0);
  endtask

  task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    int A, S, a0, armed, early, stb_n, cs_n, ack_k, cap, k;
    int n_pre, n_cs, n_adv, adv_start, n_stb, n_bad, n_after, n_addr_ad, n_data_ad;
    bit addr_bad, seen_ack, got_err;
    logic [DW-1:0] lanes, addr_seen, wd_seen, exp_rd, got_rd, exp_lanes, exp_aval;
    logic stb_a, oth_a;
    A = c_mux ? ((c_muxw > c_adv) ? int'(c_muxw) : int'(c_adv)) + 1 : int'(c_adv) + 1;
    S = (wr ? int'(c_we) : int'(c_oe)) + 1;
    a0 = int'(c_ce) + 1 + A + S + int'(c_wait) + 1 + 1;
    if (rdy_never) armed = TO;
    else if (rdy_from <= a0) armed = 1;
    else armed = rdy_from - a0 + 1;
    early = (!rdy_never && c_early) ? 1 : 0;
    stb_n = S + int'(c_wait) + 1 + armed + early;
    cs_n = A + stb_n + int'(c_hold) + 1;
    ack_k = int'(c_ce) + 1 + cs_n;
    cap = a0 + armed - 1 + early;
    exp_rd = c_wide ? (32'hC0DE_0000 | DW'(cap)) : (DW'(cap) & 32'h0000_FFFF);
    exp_lanes = c_wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    exp_aval = DW'(a) & exp_lanes;
    n_pre = 0; n_cs = 0; n_adv = 0; adv_start = 0; n_stb = 0; n_bad = 0; n_after = 0;
    n_addr_ad = 0; n_data_ad = 0; addr_bad = 0; seen_ack = 0; got_err = 0;
    lanes = '0; addr_seen = '0; wd_seen = '0; got_rd = '0; k = 0;

    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(posedge clk);
    while (!seen_ack && k < 2000) begin
      @(negedge clk);
      k++;
      stb_a = wr ? act_of(we, c_sinv) : act_of(oe, c_sinv);
      oth_a = wr ? act_of(oe, c_sinv) : act_of(we, c_sinv);
      if (oth_a) n_bad++;
      if (!act_of(cs, c_cinv) && n_cs == 0) begin
        n_pre++;
        if (baddr != a) addr_bad = 1;
      end
      if (act_of(cs, c_cinv)) begin
        n_cs++;
        if (baddr != a) addr_bad = 1;
      end
      if (act_of(adv, c_ainv)) begin
        n_adv++;
        if (adv_start == 0) adv_start = k;
        if (stb_a) n_bad++;
      end
      if (stb_a) n_stb++;
      if (act_of(cs, c_cinv) && n_stb > 0 && !stb_a) n_after++;
      if (ad_oe != '0) begin
        if (n_stb == 0 && !stb_a) begin n_addr_ad++; addr_seen = ad_o; end
        else begin n_data_ad++; lanes = ad_oe; wd_seen = ad_o; end
      end
      ad_i = 32'hC0DE_0000 | DW'(k);
      if (rdy_never) rdy = c_rinv ? 1'b0 : 1'b1;
      else rdy = c_rinv ? (k >= rdy_from) : !(k >= rdy_from);
      if (ack) begin
        seen_ack = 1; got_err = err; got_rd = rdata;
        req_valid = 0;
      end
    end
    chk(seen_ack && k == ack_k, "R1 ack cycle", k, ack_k);
    chk(n_pre == int'(c_ce) + 1 && !addr_bad, "R2 setup before cs", n_pre, int'(c_ce) + 1);
    chk(n_adv == int'(c_adv) + 1 && adv_start == int'(c_ce) + 2, "R3 adv width/start",
        n_adv, int'(c_adv) + 1);
    chk(n_addr_ad == (c_mux ? int'(c_muxw) + 1 : 0), "R4 muxed address cycles",
        n_addr_ad, c_mux ? int'(c_muxw) + 1 : 0);
    if (c_mux) chk(addr_seen == exp_aval, "R4 muxed address value", addr_seen, exp_aval);
    chk(n_stb == stb_n && n_bad == 0, "R5 strobe length (R6 wait included)", n_stb, stb_n);
    chk(n_cs == cs_n, "R4 cs span", n_cs, cs_n);
    chk(n_after == int'(c_hold) + 1, "R8 hold after strobe", n_after, int'(c_hold) + 1);
    chk(n_data_ad == (wr ? stb_n + int'(c_hold) + 1 : 0), "R9 data drive cycles",
        n_data_ad, wr ? stb_n + int'(c_hold) + 1 : 0);
    if (wr) begin
      chk(lanes == exp_lanes, "R10 driven lanes", lanes, exp_lanes);
      chk(wd_seen == (wd & exp_lanes), "R9 write data", wd_seen, wd & exp_lanes);
    end
    chk(got_err == rdy_never, "R12 error flag", got_err, rdy_never);
    if (!wr && !rdy_never)
      chk(got_rd == exp_rd, "R7 read capture (R10 width)", got_rd, exp_rd);
    @(negedge clk);
    chk_idle("after access");
  endtask

  task automatic t_reset();
    cfg_default();
    @(negedge clk);
    chk_idle("reset");
    chk(rdata == '0 && err == 0, "R1 reset outputs", rdata, 0);
  endtask

  task automatic t_write_default();
    cfg_default();
    run_txn(1, 28'h123_4567, 32'hDEAD_BEEF);
  endtask

  task automatic t_read_default();
    cfg_default();
    run_txn(0, 28'h0AB_CDE0, '0);
  endtask

  task automatic t_read_mux_early_inv();
    cfg_default();
    c_wide = 0; c_mux = 1; c_early = 1;
    c_rinv = 1; c_ainv = 1; c_sinv = 1; c_cinv = 1;
    c_ce = 0; c_adv = 2; c_muxw = 5; c_oe = 7; c_wait = 2; c_hold = 3;
    @(negedge clk);
    chk_idle("inverted R11");
    run_txn(0, 28'hF00_9A5C, '0);
  endtask

  task automatic t_read_late_ready();
    cfg_default();
    // R6: ready arrives five cycles after the block starts checking
    rdy_from = 4 + 1 + 2 + 2 + 3 + 1 + 1 + 5;
    run_txn(0, 28'h000_0010, '0);
  endtask

  task automatic t_timeout();
    cfg_default();
    rdy_never = 1;
    run_txn(0, 28'h555_0000, '0);
  endtask

  task automatic t_write_zero_mux_narrow();
    cfg_default();
    c_wide = 0; c_mux = 1;
    c_ce = 0; c_adv = 0; c_muxw = 0; c_we = 0; c_hold = 0; c_wait = 0;
    run_txn(1, 28'hABC_1234, 32'h8765_4321);
  endtask

  task automatic t_write_mux_short();
    cfg_default();
    c_mux = 1; c_adv = 6; c_muxw = 2; c_we = 9; c_early = 1;
    run_txn(1, 28'h7FF_FFFE, 32'h0F0F_A5A5);
  endtask

  initial begin
    cfg_default();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write_default();
    t_read_default();
    t_read_mux_early_inv();
    t_read_late_ready();
    t_timeout();
    t_write_zero_mux_narrow();
    t_write_mux_short();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule